// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Command Sequencer

This block owns the command pins of a single SDRAM device from reset onward. On leaving reset it turns the device clock enable on and waits a programmable number of cycles. It then closes every bank and runs a programmable number of auto-refresh cycles. Last, it writes the device mode register. From that point it raises a ready flag, and an interval timer schedules auto-refresh commands for the rest of operation.

All configuration is static and held on input pins while the block runs: CAS latency, the power-up wait, three timing counts, the number of start-up refreshes and the refresh timer reload. Every timing input holds its cycle count minus one. A command therefore reaches the pins exactly `field + 1` cycles after the command before it. The integrator computes the timer reload value as (refresh period / 2^row_bits) / SDRAM clock period − 20. For example, a 64 ms period, 12 row bits and a 7.5 ns clock give about 2063.

Read and write traffic, row management and self-refresh belong to a neighbouring block. This sequencer only guarantees that a refresh goes out on schedule while ready is high.

Top module: `sdr_init_refresh_seq`

## Requirements
- R1: While reset is high and until the first clock edge after it, clock enable and ready are low, address and bank pins are zero, and the command pins {cs_n,ras_n,cas_n,we_n} carry NOP = 4'b0111.
- R2: Clock enable rises at the first clock edge after reset. The precharge-all command appears exactly cfg_pwrup_cycles+1 cycles later, and the command pins show NOP in every cycle between them.
- R3: Precharge-all is encoded 4'b0010 on {cs_n,ras_n,cas_n,we_n}, with address bit 10 high, all other address bits low and bank address zero.
- R4: cfg_init_refs+1 auto-refresh commands (4'b0010 is precharge; auto-refresh is 4'b0001, address and bank zero) follow the precharge. The first comes cfg_trp+1 cycles after the precharge, and each later one comes cfg_trc+1 cycles after the one before.
- R5: The mode-register load (4'b0000) follows the last start-up refresh by cfg_trc+1 cycles, with bank address zero. Its address carries: bits 2:0 = 0 (burst length one), bit 3 = 0 (sequential), bits 6:4 = cfg_cas_lat (2 or 3), bits 8:7 = 0 (standard mode), bit 9 = 1 (single-location writes), and all higher bits zero.
- R6: Ready rises cfg_tmrd+1 cycles after the mode-register load and stays high until the next reset.
- R7: While ready is high, the refresh timer expires every cfg_ref_reload+1 cycles, the first expiry falling cfg_ref_reload+1 cycles after ready rises. Each expiry leads to an auto-refresh on the pins one cycle later, provided at least cfg_trc+1 cycles have passed since the previous refresh. Ready high allows no command other than auto-refresh.
- R8: An expiry that arrives while the previous refresh's cfg_trc+1 window is still open is held. The held refresh goes out on the first cycle the window allows. Several expiries held together produce a single refresh, and every cycle without a command shows NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cas_lat | input | 2 | CAS latency, 2 or 3 |
| cfg_pwrup_cycles | input | PWRUP_W | Power-up wait after clock enable, count minus one |
| cfg_trp | input | TIM_W | Precharge-to-command time, count minus one |
| cfg_trc | input | TIM_W | Refresh-to-command time, count minus one |
| cfg_tmrd | input | TIM_W | Mode-load-to-command time, count minus one |
| cfg_init_refs | input | NREF_W | Start-up refresh count minus one |
| cfg_ref_reload | input | REF_W | Refresh timer reload value |
| sd_cke | output | 1 | Device clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BA_W | Bank address |
| sd_addr | output | ADDR_W | Address bus |
| init_done | output | 1 | Start-up sequence finished, refresh running |

## Verification
A wait counter that is off by one shows up at once as a command one cycle early or late, and the per-cycle comparison flags it in that same cycle. A lost or duplicated start-up refresh moves the mode-register load by a whole cfg_trc+1 window. A wrong pending flag in the refresh path is invisible until the timer next expires inside a busy window. The short-reload scenario forces that case within about twenty cycles of ready rising, and the fault then shows as a refresh that is missing, early or doubled.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_LMR = 4'b0000,
    CMD_ARF = 4'b0001,
    CMD_PCH = 4'b0010,
    CMD_NOP = 4'b0111
  } sdr_cmd_e;

  typedef enum logic [2:0] {
    ST_CLKEN,
    ST_DELAY,
    ST_PCH_WAIT,
    ST_IARF_WAIT,
    ST_LMR_WAIT,
    ST_RUN
  } seq_st_e;

  localparam int AP_BIT = 10;

  // burst length 1, sequential, CAS latency, standard mode, single writes
  function automatic logic [9:0] mode_word(input logic [1:0] cl);
    return {1'b1, 2'b00, 1'b0, cl, 1'b0, 3'b000};
  endfunction

endpackage

// File: rtl/sdr_refresh_timer.sv
module sdr_refresh_timer #(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] reload,
  output logic             tick
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (!en) begin
      cnt  <= reload;
      tick <= 1'b0;
    end else if (cnt == '0) begin
      cnt  <= reload;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt - 1'b1;
      tick <= 1'b0;
    end
  end

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
    (tick && en && reload != '0) |=> !tick); // R7

endmodule

// File: rtl/sdr_cmd_reg.sv
module sdr_cmd_reg
  import sdr_seq_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  sdr_cmd_e          cmd_d,
  input  logic [ADDR_W-1:0] addr_d,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr
);

  always_ff @(posedge clk) begin
    if (rst) begin
      {cs_n, ras_n, cas_n, we_n} <= CMD_NOP;
      ba   <= '0;
      addr <= '0;
    end else begin
      {cs_n, ras_n, cas_n, we_n} <= cmd_d;
      ba   <= '0;
      addr <= addr_d;
    end
  end

endmodule

// File: rtl/sdr_init_refresh_seq.sv
module sdr_init_refresh_seq
  import sdr_seq_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int BA_W    = 2,
  parameter int TIM_W   = 4,
  parameter int PWRUP_W = 16,
  parameter int NREF_W  = 4,
  parameter int REF_W   = 13
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         cfg_cas_lat,
  input  logic [PWRUP_W-1:0] cfg_pwrup_cycles,
  input  logic [TIM_W-1:0]   cfg_trp,
  input  logic [TIM_W-1:0]   cfg_trc,
  input  logic [TIM_W-1:0]   cfg_tmrd,
  input  logic [NREF_W-1:0]  cfg_init_refs,
  input  logic [REF_W-1:0]   cfg_ref_reload,
  output logic               sd_cke,
  output logic               sd_cs_n,
  output logic               sd_ras_n,
  output logic               sd_cas_n,
  output logic               sd_we_n,
  output logic [BA_W-1:0]    sd_ba,
  output logic [ADDR_W-1:0]  sd_addr,
  output logic               init_done
);

  localparam int CNT_W = (PWRUP_W > TIM_W) ? PWRUP_W : TIM_W;

  seq_st_e            state, state_n;
  logic [CNT_W-1:0]   wcnt, wcnt_n;
  logic [NREF_W-1:0]  left, left_n;
  logic               cke_q, cke_n;
  logic               rdy_q, rdy_n;
  logic               req_q, tick, issue_ref;
  sdr_cmd_e           cmd_n;
  logic [ADDR_W-1:0]  addr_n;

  always_comb begin
    state_n   = state;
    wcnt_n    = wcnt;
    left_n    = left;
    cke_n     = cke_q;
    rdy_n     = rdy_q;
    cmd_n     = CMD_NOP;
    addr_n    = '0;
    issue_ref = 1'b0;
    if (state == ST_CLKEN) begin
      cke_n   = 1'b1;
      wcnt_n  = CNT_W'(cfg_pwrup_cycles);
      state_n = ST_DELAY;
    end else if (wcnt != '0) begin
      wcnt_n = wcnt - 1'b1;
    end else begin
      case (state)
        ST_DELAY: begin
          cmd_n          = CMD_PCH;
          addr_n[AP_BIT] = 1'b1;
          wcnt_n         = CNT_W'(cfg_trp);
          state_n        = ST_PCH_WAIT;
        end
        ST_PCH_WAIT: begin
          cmd_n   = CMD_ARF;
          wcnt_n  = CNT_W'(cfg_trc);
          left_n  = cfg_init_refs;
          state_n = ST_IARF_WAIT;
        end
        ST_IARF_WAIT: begin
          if (left != '0) begin
            cmd_n  = CMD_ARF;
            left_n = left - 1'b1;
            wcnt_n = CNT_W'(cfg_trc);
          end else begin
            cmd_n   = CMD_LMR;
            addr_n  = ADDR_W'(mode_word(cfg_cas_lat));
            wcnt_n  = CNT_W'(cfg_tmrd);
            state_n = ST_LMR_WAIT;
          end
        end
        ST_LMR_WAIT: begin
          rdy_n   = 1'b1;
          state_n = ST_RUN;
        end
        ST_RUN: begin
          if (req_q || tick) begin
            cmd_n     = CMD_ARF;
            wcnt_n    = CNT_W'(cfg_trc);
            issue_ref = 1'b1;
          end
        end
        default: state_n = ST_CLKEN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_CLKEN;
      wcnt  <= '0;
      left  <= '0;
      cke_q <= 1'b0;
      rdy_q <= 1'b0;
      req_q <= 1'b0;
    end else begin
      state <= state_n;
      wcnt  <= wcnt_n;
      left  <= left_n;
      cke_q <= cke_n;
      rdy_q <= rdy_n;
      req_q <= (req_q | tick) & ~issue_ref;
    end
  end

  sdr_refresh_timer #(.CNT_W(REF_W)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .en     (rdy_q),
    .reload (cfg_ref_reload),
    .tick   (tick)
  );

  sdr_cmd_reg #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_cmd (
    .clk    (clk),
    .rst    (rst),
    .cmd_d  (cmd_n),
    .addr_d (addr_n),
    .cs_n   (sd_cs_n),
    .ras_n  (sd_ras_n),
    .cas_n  (sd_cas_n),
    .we_n   (sd_we_n),
    .ba     (sd_ba),
    .addr   (sd_addr)
  );

  assign sd_cke    = cke_q;
  assign init_done = rdy_q;

  logic [3:0] pins;
  assign pins = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  AST_NOP_WHILE_CKE_LOW: assert property (@(posedge clk) disable iff (rst)
    !sd_cke |-> pins == CMD_NOP); // R1
  AST_PCH_AUTO_ALL: assert property (@(posedge clk) disable iff (rst)
    pins == CMD_PCH |-> sd_addr[AP_BIT] && sd_ba == '0); // R3
  AST_LMR_BANK0: assert property (@(posedge clk) disable iff (rst)
    pins == CMD_LMR |-> sd_ba == '0 && !init_done); // R5
  AST_READY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done); // R6
  AST_ONLY_ARF_WHEN_READY: assert property (@(posedge clk) disable iff (rst)
    (init_done && pins != CMD_NOP) |-> pins == CMD_ARF); // R7
  AST_EXPIRY_SERVED: assert property (@(posedge clk) disable iff (rst)
    (tick && state == ST_RUN && wcnt == '0) |=> pins == CMD_ARF); // R7
  AST_HELD_UNTIL_ISSUED: assert property (@(posedge clk) disable iff (rst)
    (tick && wcnt != '0) |=> req_q); // R8

endmodule

// File: tb/tb_sdr_init_refresh_seq.sv
`timescale 1ns/1ps
module tb_sdr_init_refresh_seq;

  localparam int ADDR_W = 13;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  cfg_cas_lat = 2'd3;
  logic [15:0] cfg_pwrup_cycles = '0;
  logic [3:0]  cfg_trp = '0, cfg_trc = '0, cfg_tmrd = '0;
  logic [3:0]  cfg_init_refs = '0;
  logic [12:0] cfg_ref_reload = '0;
  logic        sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, init_done;
  logic [1:0]  sd_ba;
  logic [ADDR_W-1:0] sd_addr;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sdr_init_refresh_seq dut (
    .clk(clk), .rst(rst), .cfg_cas_lat(cfg_cas_lat),
    .cfg_pwrup_cycles(cfg_pwrup_cycles), .cfg_trp(cfg_trp),
    .cfg_trc(cfg_trc), .cfg_tmrd(cfg_tmrd), .cfg_init_refs(cfg_init_refs),
    .cfg_ref_reload(cfg_ref_reload), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n),
    .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_ba(sd_ba), .sd_addr(sd_addr), .init_done(init_done)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic run_case(input int w, input int trp, input int trc,
                          input int tmrd, input int nref_m1, input int cl,
                          input int reload, input int ncyc);
    int p, tp, tc, tm, m, r, lp, next_ok, ref_cnt, held_seen;
    bit pend;
    cfg_pwrup_cycles = 16'(w); cfg_trp = 4'(trp); cfg_trc = 4'(trc);
    cfg_tmrd = 4'(tmrd); cfg_init_refs = 4'(nref_m1);
    cfg_cas_lat = 2'(cl); cfg_ref_reload = 13'(reload);
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(sd_cke == 1'b0, "R1", "cke in reset", int'(sd_cke), 0);
    chk(init_done == 1'b0, "R1", "ready in reset", int'(init_done), 0);
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R1", "cmd in reset",
        int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), 7);
    chk(sd_addr == '0 && sd_ba == '0, "R1", "addr/ba in reset", int'(sd_addr), 0);
    rst = 1'b0;
    tp = trp + 1; tc = trc + 1; tm = tmrd + 1; lp = reload + 1;
    p = w + 1;
    m = p + tp + (nref_m1 + 1) * tc;
    r = m + tm;
    next_ok = r + 1;
    pend = 0;
    ref_cnt = 0;
    held_seen = 0;
    for (int e = 0; e < ncyc; e++) begin
      logic [3:0] exp_cmd;
      int exp_addr;
      string tag;
      bit tick_vis;
      exp_cmd = 4'b0111; exp_addr = 0; tag = (e < r) ? "R2" : "R8";
      if (e == p) begin
        exp_cmd = 4'b0010; exp_addr = 'h400; tag = "R3";
      end else if (e > p && e < m && (e - p - tp) >= 0 && ((e - p - tp) % tc) == 0) begin
        exp_cmd = 4'b0001; tag = "R4";
      end else if (e == m) begin
        exp_cmd = 4'b0000; exp_addr = 'h200 | (cl << 4); tag = "R5";
      end else if (e > r) begin
        tick_vis = (e - 1 >= r + 1 + reload) && (((e - 1 - (r + 1 + reload)) % lp) == 0);
        if (tick_vis && pend) held_seen++;
        if (tick_vis && e < next_ok) held_seen++;
        pend = pend | tick_vis;
        if (pend && e >= next_ok) begin
          exp_cmd = 4'b0001; tag = "R7";
          pend = 0; next_ok = e + tc; ref_cnt++;
        end
      end
      @(posedge clk);
      @(negedge clk);
      chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == exp_cmd, tag, $sformatf("cmd at edge %0d", e),
          int'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}), int'(exp_cmd));
      chk(int'(sd_addr) == exp_addr && sd_ba == '0, tag, $sformatf("addr at edge %0d", e),
          int'(sd_addr), exp_addr);
      chk(sd_cke == 1'b1, "R2", $sformatf("cke at edge %0d", e), int'(sd_cke), 1);
      chk(init_done == (e >= r), "R6", $sformatf("ready at edge %0d", e),
          int'(init_done), int'(e >= r));
    end
    // R7 refresh activity observed in run phase
    chk(ref_cnt > 0, "R7", "run-phase refreshes seen by model", ref_cnt, 1);
    $display("case w=%0d reload=%0d: refreshes=%0d held_expiries=%0d", w, reload, ref_cnt, held_seen);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog all-reqs: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R4 with two start-up refreshes, CL3, long reload (R7 without overlap)
    run_case(20, 2, 7, 1, 1, 3, 30, 200);
    // R8: reload shorter than tRC window, single start-up refresh, CL2
    run_case(5, 0, 7, 0, 0, 2, 2, 120);
    // zero power-up wait, four start-up refreshes, reload equal to window
    run_case(0, 1, 3, 2, 3, 3, 3, 90);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule